// File: doc/BRIEF.md
# Sector Hamming Code Checker and Single-Bit Repairer

This block protects one sector of NAND data with a 24-bit single-error-correcting Hamming code. A byte stream passes through a parity accumulator. The accumulator keeps a line and column parity pair for every bit of a 12-bit bit address. The raw parity word is packed and inverted into a 24-bit code. On a write, that code is the value to store next to the sector. A sector of all-ones bytes then gives an all-ones code, which is exactly what an erased page already holds.

On a read, the sector is streamed through again. The controller then pulses `chk_start` with the code that was read from the spare area. The block XORs the stored code with the freshly computed one and sorts the difference into four cases:
- clean;
- a single flipped data bit, which it repairs in the external sector buffer through a read-modify-write port;
- a single flipped bit inside the code itself, which needs no data change;
- an uncorrectable pattern.

The result is reported as a status code together with a one-cycle `done` pulse.

The data input is a valid/ready stream. A byte is taken on every cycle where `s_valid` and `s_ready` are both high. The sender must hold `s_data` stable while `s_ready` is low. `s_ready` drops in three cases: while `acc_clear` is high, once a full sector has been taken since the last clear, and while a check is in progress.

Top module: `hecc_sector_fixer`

## Requirements
- R1: For a byte at index i (counted from 0 after `acc_clear`), data bit b has the 12-bit address A = i*8+b. High parity bit k is the XOR of all data bits whose A has bit k set. Low parity bit k is the XOR of all data bits whose A has bit k clear. `acc_clear` zeroes both halves and the byte count.
- R2: The raw parity word holds the low half in bits 11:0 and the high half in bits 27:16; all other raw bits are zero and discarded. `calc_code` is the bitwise inverse of {high, low}. Byte 0 of the stored code is `calc_code[7:0]`, byte 1 is `[15:8]` and byte 2 is `[23:16]`. After reset, and for an all-0xFF sector, `calc_code` is 24'hFFFFFF.
- R3: `s_ready` is low while `acc_clear` is high, after SECTOR_BYTES bytes have been taken since the last clear, and while a check is busy. Bytes offered while `s_ready` is low do not change `calc_code`.
- R4: A zero difference (`stored_code` XOR `calc_code`) gives status 2'b00 (clean) and no buffer access.
- R5: When the upper 12 bits of the difference XOR the lower 12 bits equal 12'hFFF, and the byte index (difference bits 23:15) is below SECTOR_BYTES, the block reads that byte. It then writes it back XORed with (1 << difference bits 14:12) and reports status 2'b01 (corrected).
- R6: A pattern that passes the 12'hFFF test but has a byte index of SECTOR_BYTES or more gives status 2'b10 (uncorrectable) and no buffer access.
- R7: A difference with exactly one bit set gives status 2'b01 and leaves the buffer untouched.
- R8: Every other nonzero difference gives status 2'b10 and no buffer access.
- R9: `done` is high for exactly one cycle per accepted `chk_start`. `status` is valid while `done` is high and holds until the next result. After reset, `status` is 2'b00 and `done` is 0. A `chk_start` that arrives while a check is busy is ignored.
- R10: `buf_rdata` returns the byte at `buf_addr` one cycle after `buf_rd`. `buf_wr` follows `buf_rd` in the next cycle, at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_clear | input | 1 | Restart parity accumulation for a new sector |
| s_valid | input | 1 | Data byte valid |
| s_ready | output | 1 | Data byte accepted when high together with s_valid |
| s_data | input | 8 | Sector data byte |
| calc_code | output | 24 | Packed, inverted code of the bytes taken so far |
| chk_start | input | 1 | Start comparison against stored_code |
| stored_code | input | 24 | Code read back from the spare area, byte 0 in bits 7:0 |
| buf_rd | output | 1 | Sector buffer read strobe |
| buf_wr | output | 1 | Sector buffer write strobe |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Byte returned by the buffer one cycle after buf_rd |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
With a real sector, a single data-bit flip can never produce a correctable pattern whose byte index lies beyond the sector, and it can never produce a flip in the code alone. Those two branches are the hardest to reach from the ports. The bench builds the DUT with a 32-byte sector so that 9-bit byte indices above 31 exist. It then feeds `stored_code` values made by XORing the computed code with hand-built differences: a complementary pair that names byte 40, and each of the 24 one-hot patterns. Separately, it sweeps every one of the 256 single data-bit flips through the real streaming path and checks that the buffer is restored.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int RAW_W  = 32;
  localparam int PAD_W  = 16 - HALF_W;
  localparam int BIT_W  = 3;
  localparam int IDX_W  = HALF_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_BAD   = 2'b10
  } status_e;

  typedef enum logic [1:0] {
    CL_CLEAN,
    CL_DATA,
    CL_CODE,
    CL_BAD
  } class_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_EVAL,
    F_READ,
    F_WRITE,
    F_DONE
  } fsm_e;

  // Bits of a byte whose in-byte index has bit k set.
  function automatic logic [7:0] col_mask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/hecc_parity_acc.sv
module hecc_parity_acc
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             busy,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic [RAW_W-1:0] raw_par
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SECTOR_BYTES);

  logic [CNT_W-1:0]  cnt_q;
  logic [HALF_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic              take;
  logic              row_par;

  assign s_ready = !busy && !clear && (cnt_q < LIMIT);
  assign take    = s_valid && s_ready;
  assign row_par = ^s_data;

  // Column bits: address bits inside the byte.
  for (genvar k = 0; k < BIT_W; k++) begin : g_col
    localparam logic [7:0] M = col_mask(k);
    assign hi_d[k] = hi_q[k] ^ (^(s_data & M));
    assign lo_d[k] = lo_q[k] ^ (^(s_data & ~M));
  end

  // Line bits: address bits of the byte index.
  for (genvar k = BIT_W; k < HALF_W; k++) begin : g_row
    assign hi_d[k] = hi_q[k] ^ (row_par & cnt_q[k-BIT_W]);
    assign lo_d[k] = lo_q[k] ^ (row_par & ~cnt_q[k-BIT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign raw_par = {{PAD_W{1'b0}}, hi_q, {PAD_W{1'b0}}, lo_q};

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  assert_hold_when_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !clear) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/hecc_code_pack.sv
module hecc_code_pack
  import hecc_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_par,
  output logic [CODE_W-1:0] code
);
  logic unused_raw;
  assign unused_raw = ^{raw_par[31:28], raw_par[15:12]};
  assign code = ~{raw_par[16 +: HALF_W], raw_par[0 +: HALF_W]};
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] diff,
  output class_e            cls,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BIT_W-1:0]  bit_idx
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(SECTOR_BYTES);

  logic complementary;
  assign byte_idx      = diff[CODE_W-1 -: IDX_W];
  assign bit_idx       = diff[HALF_W +: BIT_W];
  assign complementary = (diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == {HALF_W{1'b1}};

  always_comb begin
    if (diff == '0)
      cls = CL_CLEAN;
    else if (complementary)
      cls = ({1'b0, byte_idx} < LIMIT) ? CL_DATA : CL_BAD;
    else if ($onehot(diff))
      cls = CL_CODE;
    else
      cls = CL_BAD;
  end
endmodule

// File: rtl/hecc_sector_fixer.sv
module hecc_sector_fixer
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_clear,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  output logic [23:0] calc_code,
  input  logic        chk_start,
  input  logic [23:0] stored_code,
  output logic        buf_rd,
  output logic        buf_wr,
  output logic [8:0]  buf_addr,
  output logic [7:0]  buf_wdata,
  input  logic [7:0]  buf_rdata,
  output logic        done,
  output logic [1:0]  status
);
  fsm_e              state_q;
  status_e           status_q;
  logic [CODE_W-1:0] diff_q;
  logic [IDX_W-1:0]  addr_q;
  logic [7:0]        mask_q;
  logic [RAW_W-1:0]  raw_par;
  class_e            cls;
  logic [IDX_W-1:0]  byte_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic              busy;

  assign busy = (state_q != F_IDLE);

  hecc_parity_acc #(.SECTOR_BYTES(SECTOR_BYTES)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .busy(busy),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .raw_par(raw_par)
  );

  hecc_code_pack u_pack (.raw_par(raw_par), .code(calc_code));

  hecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .diff(diff_q), .cls(cls), .byte_idx(byte_idx), .bit_idx(bit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= F_IDLE;
      status_q <= ST_CLEAN;
      diff_q   <= '0;
      addr_q   <= '0;
      mask_q   <= '0;
    end else begin
      case (state_q)
        F_IDLE: if (chk_start) begin
          diff_q  <= stored_code ^ calc_code;
          state_q <= F_EVAL;
        end
        F_EVAL: begin
          case (cls)
            CL_CLEAN: begin status_q <= ST_CLEAN; state_q <= F_DONE; end
            CL_CODE:  begin status_q <= ST_FIXED; state_q <= F_DONE; end
            CL_DATA:  begin
              addr_q  <= byte_idx;
              mask_q  <= 8'b1 << bit_idx;
              state_q <= F_READ;
            end
            default:  begin status_q <= ST_BAD; state_q <= F_DONE; end
          endcase
        end
        F_READ:  state_q <= F_WRITE;
        F_WRITE: begin status_q <= ST_FIXED; state_q <= F_DONE; end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  assign buf_rd    = (state_q == F_READ);
  assign buf_wr    = (state_q == F_WRITE);
  assign buf_addr  = addr_q;
  assign buf_wdata = buf_rdata ^ mask_q;
  assign done      = (state_q == F_DONE);
  assign status    = status_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_wr_follows_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> $past(buf_rd));
  assert_clean_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == F_EVAL && diff_q == '0) |=> (done && status == ST_CLEAN && !buf_rd));
  assert_codebit_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == F_EVAL && $onehot(diff_q)) |=> (done && status == ST_FIXED && !buf_rd));
  assert_busy_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !s_ready);
endmodule

// File: tb/hecc_sector_fixer_tb.sv
`timescale 1ns/1ps
module hecc_sector_fixer_tb;
  localparam int NB = 32;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic acc_clear = 0, s_valid = 0, chk_start = 0;
  logic [7:0] s_data = 0;
  logic [23:0] stored_code = 0;
  logic s_ready, buf_rd, buf_wr, done;
  logic [23:0] calc_code;
  logic [8:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata;
  logic [1:0] status;

  always #4 clk = ~clk;

  hecc_sector_fixer #(.SECTOR_BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_clear(acc_clear), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .calc_code(calc_code),
    .chk_start(chk_start), .stored_code(stored_code), .buf_rd(buf_rd),
    .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .done(done), .status(status)
  );

  logic [7:0] mem [NB];
  logic [7:0] orig [NB];
  logic [7:0] rdata_q = 0;
  int wr_count = 0, rd_count = 0;
  assign buf_rdata = rdata_q;
  always @(posedge clk) begin
    if (buf_rd) begin rdata_q <= mem[buf_addr[AW-1:0]]; rd_count++; end
    if (buf_wr) begin mem[buf_addr[AW-1:0]] <= buf_wdata; wr_count++; end
  end

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code();
    logic [11:0] hi, lo;
    hi = 0; lo = 0;
    for (int i = 0; i < NB; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          logic [11:0] a;
          a = 12'(i * 8 + b);
          hi ^= a;
          lo ^= ~a;
        end
    return ~{hi, lo};
  endfunction

  function automatic bit mem_is_orig();
    for (int i = 0; i < NB; i++) if (mem[i] !== orig[i]) return 0;
    return 1;
  endfunction

  task automatic send_sector();
    @(negedge clk) acc_clear = 1;
    #1;
    check(s_ready == 0, "R3", "ready low during clear", 32'(s_ready), 0);
    @(negedge clk) acc_clear = 0;
    for (int i = 0; i < NB; ) begin
      bit acc;
      s_data  = mem[i];
      s_valid = ((cyc % 7) != 6);
      cyc++;
      #1;
      acc = s_valid && s_ready;
      @(negedge clk);
      if (acc) i++;
    end
    s_valid = 0;
  endtask

  task automatic run_check(input logic [23:0] code, output logic [1:0] st);
    int n;
    @(negedge clk) begin chk_start = 1; stored_code = code; end
    @(negedge clk) chk_start = 0;
    n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    st = status;
    check(done == 1, "R9", "done seen", 32'(done), 1);
    @(negedge clk);
    check(done == 0, "R9", "done one cycle", 32'(done), 0);
  endtask

  task automatic load_pattern(input int p);
    for (int i = 0; i < NB; i++) begin
      orig[i] = 8'((i * 37 + p * 91 + 5) ^ (p * i));
      mem[i]  = orig[i];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    logic [23:0] good, d;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    check(calc_code == 24'hFFFFFF, "R2", "reset code", 32'(calc_code), 32'hFFFFFF);
    check(status == 2'b00, "R9", "reset status", 32'(status), 0);
    check(done == 0, "R9", "reset done", 32'(done), 0);
    check(s_ready == 1, "R3", "reset ready", 32'(s_ready), 1);

    // Erased sector -> all-ones code
    for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; orig[i] = 8'hFF; end
    send_sector();
    check(calc_code == 24'hFFFFFF, "R2", "erased code", 32'(calc_code), 32'hFFFFFF);
    run_check(24'hFFFFFF, st);
    check(st == 2'b00, "R4", "erased clean", 32'(st), 0);

    // Code values over several patterns (R1 accumulation, R2 packing)
    for (int p = 0; p < 4; p++) begin
      load_pattern(p);
      send_sector();
      check(calc_code == ref_code(), "R1", "pattern code", 32'(calc_code), 32'(ref_code()));
    end

    // Overflow past sector size and stalled bytes ignored (R3)
    good = calc_code;
    check(s_ready == 0, "R3", "ready low when full", 32'(s_ready), 0);
    s_valid = 1; s_data = 8'h01;
    repeat (3) @(negedge clk);
    s_valid = 0;
    check(calc_code == good, "R3", "extra bytes ignored", 32'(calc_code), 32'(good));

    // Clean check with no buffer access (R4), ready low while busy (R3)
    w0 = wr_count; r0 = rd_count;
    @(negedge clk) begin chk_start = 1; stored_code = good; end
    @(negedge clk) chk_start = 0;
    check(s_ready == 0, "R3", "ready low while busy", 32'(s_ready), 0);
    while (!done) @(negedge clk);
    check(status == 2'b00, "R4", "clean status", 32'(status), 0);
    @(negedge clk);
    check(rd_count == r0 && wr_count == w0, "R4", "no access", 32'(rd_count + wr_count), 32'(r0 + w0));

    // Sweep every single data-bit flip (R5, R10)
    load_pattern(1);
    send_sector();
    good = calc_code;
    for (int k = 0; k < NB * 8; k++) begin
      for (int i = 0; i < NB; i++) mem[i] = orig[i];
      mem[k / 8][k % 8] = ~mem[k / 8][k % 8];
      send_sector();
      check(calc_code == ref_code(), "R1", "flipped code", 32'(calc_code), 32'(ref_code()));
      w0 = wr_count;
      run_check(good, st);
      check(st == 2'b01, "R5", "data flip status", 32'(st), 1);
      check(mem_is_orig(), "R5", "byte restored", 32'(k), 32'(k));
      check(wr_count == w0 + 1, "R10", "one write", 32'(wr_count), 32'(w0 + 1));
    end

    // Errors in the code only (R7)
    for (int i = 0; i < NB; i++) mem[i] = orig[i];
    send_sector();
    for (int k = 0; k < 24; k++) begin
      w0 = wr_count; r0 = rd_count;
      run_check(good ^ (24'h1 << k), st);
      check(st == 2'b01, "R7", "code bit status", 32'(st), 1);
      check(wr_count == w0 && rd_count == r0 && mem_is_orig(), "R7", "buffer untouched",
            32'(wr_count), 32'(w0));
    end

    // Complementary pattern naming byte 40, beyond 32-byte sector (R6)
    d = {12'(40 * 8 + 2), ~12'(40 * 8 + 2)};
    w0 = wr_count;
    run_check(good ^ d, st);
    check(st == 2'b10, "R6", "out of range status", 32'(st), 2);
    check(wr_count == w0 && mem_is_orig(), "R6", "no write", 32'(wr_count), 32'(w0));

    // Two-bit code difference and two data flips (R8)
    run_check(good ^ 24'h000003, st);
    check(st == 2'b10, "R8", "two code bits", 32'(st), 2);
    mem[0][0] = ~mem[0][0];
    mem[5][3] = ~mem[5][3];
    send_sector();
    w0 = wr_count;
    run_check(good, st);
    check(st == 2'b10, "R8", "two data flips", 32'(st), 2);
    check(wr_count == w0, "R8", "no write", 32'(wr_count), 32'(w0));

    // chk_start while busy is ignored: one done only (R9)
    @(negedge clk) begin chk_start = 1; stored_code = good; end
    @(negedge clk) chk_start = 1;
    @(negedge clk) chk_start = 0;
    w0 = 0;
    repeat (8) begin if (done) w0++; @(negedge clk); end
    check(w0 == 1, "R9", "single done for overlapping start", 32'(w0), 1);
    check(status == 2'b10, "R9", "status held", 32'(status), 2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule